// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable behavioural model of a word-organized asynchronous static memory with two independently selected byte lanes. A host controller drives the active-low strobes (chip enable, output enable, write enable and one select per lane) together with an address and write data. The model returns read data on a split bus: a data output plus a per-lane drive enable that a pad ring or a bench can turn into tri-state lanes.

The strobes are asynchronous by nature, so the model samples them with a clock much faster than the access time. A write is stored when the write overlap of a lane closes. The overlap of a lane is chip enable, write enable and that lane's select all low together, and it closes at the first sample where any of those three has returned high. Address and data are taken from the last sample inside the overlap, so data may be withdrawn in the same sample that closes the write. A read drives only the lanes whose select is low, one sample clock after the strobes are seen. An optional checker pulses a flag when a write overlap was shorter than a configured number of sample clocks.

The storage depth is a parameter. Only the low address bits that index the storage are decoded, and the remaining high bits alias. Stored contents are not cleared by reset.

Top module: `lane_sram_model`

## Requirements
- R1: Lane 0 is data bits 7:0 and is selected by `sel_n[0]` low; lane 1 is data bits 15:8 and is selected by `sel_n[1]` low. A read with only one lane selected drives only that lane.
- R2: When `ce_n` is high, or when both `sel_n` bits are high, `dout_en` is 00 after the next clock edge, whatever `oe_n`, `we_n`, address and data are. Write strobes applied in that state change no stored byte.
- R3: With `ce_n` low and both `oe_n` and `we_n` high, `dout_en` is 00 after the next clock edge, even though a lane is selected.
- R4: With `ce_n` low, `oe_n` low and `we_n` high, each selected lane has its `dout_en` bit set after the next clock edge and presents its stored byte. Every lane whose `dout_en` bit is 0 presents all zeros on `dout`.
- R5: A lane's byte is stored only through an overlap of low `ce_n`, low `we_n` and low select on that lane. `oe_n` has no effect on writing, and a lane that is not selected keeps its previous byte.
- R6: Whenever `we_n` was sampled low at a clock edge, `dout_en` is 00 after that edge. This holds in particular when a select or `ce_n` falls together with or after `we_n`.
- R7: Each lane commits at the first edge where its own overlap is no longer present. It stores the address and data sampled at the previous edge, so data that changes in the closing sample is not stored (zero hold). Any of `ce_n`, `we_n` or the lane's select may close the overlap.
- R8: A read of the same address at the edge where a write closes returns the newly written bytes.
- R9: The storage index is the low `STORE_AW` bits of `addr` (10 by default). Addresses that differ only above those bits reach the same word.
- R10: With the checker enabled, `ovl_short` is high for exactly one cycle after the closing edge of any lane overlap that was present at fewer than `MIN_OVL` (default 3) consecutive edges. The write is still stored.
- R11: While `rst_n` is low at a clock edge, `dout_en`, `dout` and `ovl_short` are all zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| sel_n | input | LANES (2) | Per-lane byte select, active low; bit 0 is the lower byte |
| addr | input | ADDR_W (18) | Word address |
| din | input | LANES*LANE_W (16) | Write data |
| dout | output | LANES*LANE_W (16) | Read data; zero on lanes not driving |
| dout_en | output | LANES (2) | Per-lane drive enable for `dout` |
| ovl_short | output | 1 | One-cycle pulse: a write overlap closed too early |

## Verification
The assertions take for granted that all strobes are stable across each sample edge, which is the same as treating the sampled values as the device pins. They also assume that every access lasts at least one full sample period, so no strobe glitch is shorter than the clock. The stimulus changes every input only on the falling clock edge and holds each pattern for at least one full period. It uses both short and long overlaps, and it closes writes with each of the three qualifying strobes. Read-back is compared only at addresses the stimulus has already written.

// File: rtl/lsm_pkg.sv
// Shared types for the byte-lane memory model.
// Assumes strobes are active low and already sampled or stable when decoded.
package lsm_pkg;

    // Whole-device access mode decoded from the common strobes.
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OFF     = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } bus_mode_e;

    // Classify the strobes; write enable takes priority over output enable.
    function automatic bus_mode_e classify(input logic ce_n, input logic oe_n,
                                           input logic we_n, input logic any_sel);
        if (ce_n || !any_sel) return MODE_STANDBY;
        if (!we_n)            return MODE_WRITE;
        if (!oe_n)            return MODE_READ;
        return MODE_OFF;
    endfunction

endpackage

// File: rtl/lsm_strobe_decode.sv
// Strobe decoder: turns the raw strobes into a per-lane write-overlap flag
// and a per-lane read-drive request. Purely combinational.
// Assumes one active-low select per lane.
module lsm_strobe_decode
    import lsm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [LANES-1:0] sel_n,
    output logic [LANES-1:0] ovl,
    output logic [LANES-1:0] rd
);

    bus_mode_e mode;

    // Device mode from the common strobes.
    always_comb mode = classify(ce_n, oe_n, we_n, ~&sel_n);

    // Per-lane qualification by the lane's own select.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            ovl[l] = (mode == MODE_WRITE) && !sel_n[l];
            rd[l]  = (mode == MODE_READ)  && !sel_n[l];
        end
    end

endmodule

// File: rtl/lsm_lane_store.sv
// One byte lane of storage: writes on commit, registers read data one
// sample after a read request, and forwards a byte committed in the same
// cycle to a read of the same index. Storage is not reset.
// Assumes commit is already gated by reset in the parent.
module lsm_lane_store #(
    parameter int STORE_AW = 10,
    parameter int LANE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [STORE_AW-1:0] wr_idx,
    input  logic [LANE_W-1:0]   wr_byte,
    input  logic                rd_en,
    input  logic [STORE_AW-1:0] rd_idx,
    output logic [LANE_W-1:0]   dout_byte,
    output logic                dout_on
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [LANE_W-1:0] cells [DEPTH];

    // Store the committed byte; contents survive reset.
    always_ff @(posedge clk) begin
        if (commit) cells[wr_idx] <= wr_byte;
    end

    // Register read data and lane drive, forwarding a same-cycle commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_on   <= 1'b0;
            dout_byte <= '0;
        end else if (rd_en) begin
            dout_on   <= 1'b1;
            dout_byte <= (commit && (wr_idx == rd_idx)) ? wr_byte : cells[rd_idx];
        end else begin
            dout_on   <= 1'b0;
            dout_byte <= '0;
        end
    end

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_on |-> (dout_byte == '0));

    assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && commit && (wr_idx == rd_idx)) |=> (dout_on && dout_byte == $past(wr_byte)));

endmodule

// File: rtl/lsm_overlap_check.sv
// Write-overlap length checker: counts consecutive edges at which each
// lane's overlap is present and pulses a flag when a lane commits after
// fewer than MIN_OVL such edges.
// Assumes MIN_OVL >= 1.
module lsm_overlap_check #(
    parameter int LANES   = 2,
    parameter int MIN_OVL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] ovl_now,
    input  logic [LANES-1:0] commit,
    output logic             short_flag
);

    localparam int            CW  = $clog2(MIN_OVL + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_OVL);

    logic [LANES-1:0] short_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_run
        logic [CW-1:0] run;

        // Saturating count of consecutive overlap edges for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)          run <= '0;
            else if (ovl_now[l]) run <= (run == LIM) ? run : run + CW'(1);
            else                 run <= '0;
        end

        assign short_hit[l] = commit[l] && (run < LIM);
    end

    // One-cycle pulse on any short commit.
    always_ff @(posedge clk) begin
        if (!rst_n) short_flag <= 1'b0;
        else        short_flag <= |short_hit;
    end

    assert_flag_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        short_flag |-> $past(|commit));

endmodule

// File: rtl/lane_sram_model.sv
// Byte-lane asynchronous static memory model, sampled on a fast clock.
// Decodes the raw strobes, keeps one sample of the previous write overlap,
// commits each lane when its overlap closes (using the previous sample's
// address and data), and drives read data one sample after a read request.
// Assumes strobes are held for at least one full sample period.
module lane_sram_model
    import lsm_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int STORE_AW  = 10,
    parameter int LANE_W    = 8,
    parameter int LANES     = 2,
    parameter bit CHECK_OVL = 1'b1,
    parameter int MIN_OVL   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    oe_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        sel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic [LANES-1:0]        dout_en,
    output logic                    ovl_short
);

    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]    ovl_now;
    logic [LANES-1:0]    rd_now;
    logic [LANES-1:0]    ovl_prev;
    logic [LANES-1:0]    commit;
    logic                s_ce_n;
    logic                s_we_n;
    logic [LANES-1:0]    s_sel_n;
    logic [STORE_AW-1:0] s_idx;
    logic [DATA_W-1:0]   s_din;

    // Address bits above the storage index alias and are not decoded.
    if (ADDR_W > STORE_AW) begin : g_hi
        logic unused_addr_hi;
        assign unused_addr_hi = ^addr[ADDR_W-1:STORE_AW];
    end

    lsm_strobe_decode #(.LANES(LANES)) u_decode (
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .sel_n (sel_n),
        .ovl   (ovl_now),
        .rd    (rd_now)
    );

    // Keep one sample of strobes, overlap, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ce_n   <= 1'b1;
            s_we_n   <= 1'b1;
            s_sel_n  <= '1;
            s_idx    <= '0;
            s_din    <= '0;
            ovl_prev <= '0;
        end else begin
            s_ce_n   <= ce_n;
            s_we_n   <= we_n;
            s_sel_n  <= sel_n;
            s_idx    <= addr[STORE_AW-1:0];
            s_din    <= din;
            ovl_prev <= ovl_now;
        end
    end

    // A lane commits on the first sample its overlap is gone.
    assign commit = ovl_prev & ~ovl_now & {LANES{rst_n}};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lsm_lane_store #(.STORE_AW(STORE_AW), .LANE_W(LANE_W)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .commit    (commit[l]),
            .wr_idx    (s_idx),
            .wr_byte   (s_din[l*LANE_W +: LANE_W]),
            .rd_en     (rd_now[l]),
            .rd_idx    (addr[STORE_AW-1:0]),
            .dout_byte (dout[l*LANE_W +: LANE_W]),
            .dout_on   (dout_en[l])
        );

        assert_lane_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
            dout_en[l] |-> !s_sel_n[l]);

        assert_commit_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
            commit[l] |=> !ovl_prev[l]);
    end

    if (CHECK_OVL) begin : g_chk
        lsm_overlap_check #(.LANES(LANES), .MIN_OVL(MIN_OVL)) u_chk (
            .clk        (clk),
            .rst_n      (rst_n),
            .ovl_now    (ovl_now),
            .commit     (commit),
            .short_flag (ovl_short)
        );
    end else begin : g_nochk
        assign ovl_short = 1'b0;
    end

    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ce_n || (&s_sel_n)) |-> (dout_en == '0));

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s_we_n |-> (dout_en == '0));

endmodule

// File: tb/lane_sram_model_bench.sv
// Scoreboard bench: driver tasks apply one strobe pattern per clock and push
// the expected outputs; a monitor pops and compares on the falling edge.
module lane_sram_model_bench;

    localparam int MIN = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [1:0]  sel_n = 2'b11;
    logic [17:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  dout_en;
    logic        ovl_short;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0]  en;
        logic [15:0] d;
        logic        sh;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] refm [int];

    always #5 clk = ~clk;

    lane_sram_model u_lane_sram_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .sel_n(sel_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .ovl_short(ovl_short)
    );

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dout_en !== e.en || dout !== e.d || ovl_short !== e.sh) begin
                fails++;
                $display("FAIL %s: got en=%b d=%h sh=%b, expected en=%b d=%h sh=%b",
                         e.tag, dout_en, dout, ovl_short, e.en, e.d, e.sh);
            end
        end
    end

    task automatic expect_out(input logic [1:0] en, input logic [15:0] d,
                              input logic sh, input string tag);
        exp_t e;
        e.en = en; e.d = d; e.sh = sh; e.tag = tag;
        q.push_back(e);
    endtask

    // Apply one pattern for one clock edge.
    task automatic cyc(input logic c, input logic o, input logic w,
                       input logic [1:0] s, input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; sel_n = s; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    function automatic int idx(input logic [17:0] a);
        return int'(a[9:0]);
    endfunction

    // Write through a we-closed overlap of 'hold' edges; data flips on close.
    task automatic wr(input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] s, input int hold, input string tag);
        logic [15:0] old;
        for (int i = 0; i < hold; i++) begin
            cyc(1'b0, 1'b1, 1'b0, s, a, d);
            expect_out(2'b00, 16'h0, 1'b0, tag);
        end
        cyc(1'b0, 1'b1, 1'b1, 2'b11, a, ~d);
        expect_out(2'b00, 16'h0, (hold < MIN), tag);
        old = refm.exists(idx(a)) ? refm[idx(a)] : 16'h0;
        if (!s[0]) old[7:0]  = d[7:0];
        if (!s[1]) old[15:8] = d[15:8];
        refm[idx(a)] = old;
    endtask

    task automatic rd(input logic [17:0] a, input logic [1:0] s, input string tag);
        logic [15:0] e;
        e = refm[idx(a)];
        if (s[0]) e[7:0]  = 8'h00;
        if (s[1]) e[15:8] = 8'h00;
        cyc(1'b0, 1'b0, 1'b1, s, a, 16'h0);
        expect_out(~s, e, 1'b0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [17:0] a1 = 18'h00012;
        logic [17:0] a2 = 18'h003FF;
        logic [17:0] a3 = 18'h20155;

        // R11: reset state
        repeat (2) @(posedge clk);
        #1;
        expect_out(2'b00, 16'h0, 1'b0, "R11 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R5, R4: full-word writes and reads
        wr(a1, 16'hA55A, 2'b00, 4, "R5 full write");
        wr(a2, 16'h1234, 2'b00, 4, "R5 full write");
        wr(a3, 16'h9C63, 2'b00, 4, "R5 full write");
        rd(a1, 2'b00, "R4 read a1");
        rd(a2, 2'b00, "R4 read a2");
        rd(a3, 2'b00, "R4 read a3");

        // R1: single-lane reads
        rd(a1, 2'b10, "R1 lower only");
        rd(a1, 2'b01, "R1 upper only");

        // R5: upper-only write keeps the lower byte
        wr(a1, 16'hC3FF, 2'b01, 4, "R5 upper write");
        rd(a1, 2'b00, "R5 lower kept");

        // R2: standby forms, and ignored write strobes while deselected
        cyc(1'b1, 1'b0, 1'b1, 2'b00, a1, 16'h0);
        expect_out(2'b00, 16'h0, 1'b0, "R2 chip off");
        cyc(1'b0, 1'b0, 1'b1, 2'b11, a1, 16'h0);
        expect_out(2'b00, 16'h0, 1'b0, "R2 no lanes");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 2'b00, a1, 16'hFFFF);
            expect_out(2'b00, 16'h0, 1'b0, "R2 stray write");
        end
        cyc(1'b1, 1'b1, 1'b1, 2'b11, a1, 16'h0);
        expect_out(2'b00, 16'h0, 1'b0, "R2 idle");
        rd(a1, 2'b00, "R2 nothing stored");

        // R3: output disable
        cyc(1'b0, 1'b1, 1'b1, 2'b00, a1, 16'h0);
        expect_out(2'b00, 16'h0, 1'b0, "R3 output off");

        // R6/R5: oe low during write, selects arrive after we falls; close on select
        cyc(1'b0, 1'b0, 1'b0, 2'b11, a2, 16'h5AA5);
        expect_out(2'b00, 16'h0, 1'b0, "R6 we first");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 2'b00, a2, 16'h5AA5);
            expect_out(2'b00, 16'h0, 1'b0, "R6 oe low write");
        end
        cyc(1'b0, 1'b0, 1'b0, 2'b11, a2, 16'h0000);
        expect_out(2'b00, 16'h0, 1'b0, "R7 select close");
        refm[idx(a2)] = 16'h5AA5;
        rd(a2, 2'b00, "R7 select-closed data");

        // R7: chip-enable-closed write
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 2'b00, a3, 16'h7E81);
            expect_out(2'b00, 16'h0, 1'b0, "R7 ce write");
        end
        cyc(1'b1, 1'b1, 1'b0, 2'b00, a3, 16'h0000);
        expect_out(2'b00, 16'h0, 1'b0, "R7 ce close");
        refm[idx(a3)] = 16'h7E81;
        rd(a3, 2'b00, "R7 ce-closed data");

        // R7: lanes close at different edges with different data
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 2'b00, a1, 16'h1122);
            expect_out(2'b00, 16'h0, 1'b0, "R7 both lanes");
        end
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 2'b01, a1, 16'h3344);
            expect_out(2'b00, 16'h0, 1'b0, "R7 upper continues");
        end
        cyc(1'b0, 1'b1, 1'b1, 2'b11, a1, 16'hFFFF);
        expect_out(2'b00, 16'h0, 1'b0, "R7 upper close");
        refm[idx(a1)] = 16'h3322;
        rd(a1, 2'b00, "R7 per-lane commit");

        // R8: read of the same word on the closing edge
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 2'b00, a2, 16'hD00D);
            expect_out(2'b00, 16'h0, 1'b0, "R8 write");
        end
        cyc(1'b0, 1'b0, 1'b1, 2'b00, a2, 16'h0BAD);
        expect_out(2'b11, 16'hD00D, 1'b0, "R8 forward");
        refm[idx(a2)] = 16'hD00D;
        rd(a2, 2'b00, "R8 stored");

        // R9: aliasing above the storage index
        wr(a2 | 18'h00400, 16'hBEEF, 2'b00, 4, "R9 alias write");
        rd(a2, 2'b00, "R9 alias read");

        // R10: short overlap is flagged and still stored
        wr(a3, 16'h0F0F, 2'b00, 1, "R10 short write");
        rd(a3, 2'b00, "R10 stored, flag cleared");
        wr(a3, 16'hF0F0, 2'b10, 3, "R10 exact minimum");
        rd(a3, 2'b00, "R10 lower updated");

        cyc(1'b1, 1'b1, 1'b1, 2'b11, a1, 16'h0);
        expect_out(2'b00, 16'h0, 1'b0, "R2 final idle");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule